// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a charge-redistribution successive-approximation converter. A start strobe launches a sequence over a group of four or eight analog channels. Each conversion passes through four timed phases. The first is an initial sample, with the selected channel routed into the sample buffer. The second is a transfer, with the sample path cut off from the multiplexer. The third is a final sample of programmable length. The last is a resolution phase, in which one result bit is decided per converter clock, starting at the most significant bit. The sample capacitor, the DAC array and the comparator are outside the block. The block drives strobes that mark each phase, the channel select and the trial DAC code, and it reads back a single comparator decision.

Each finished conversion is written into the result register of its channel and raises that channel's completion flag. After the last channel of the group, a sequence-complete flag is raised and the block goes idle. All phase timing advances only on cycles where the converter clock enable is high, so a slow converter clock is derived from the system clock by gating rather than by a second clock domain.

Top module: `sar_seq`

## Requirements
- R1: A high `start` acts on the next clock edge whether or not `adc_ce` is high. It clears every completion flag and `seq_done`, selects channel 0 and enters the initial sample phase. The `res10`, `sts` and `mode8` inputs are captured at that edge and hold for the whole sequence. A start during a running sequence restarts it in the same way.
- R2: The initial sample phase (`ph_init` high) lasts exactly 2 enabled clocks. At most one phase strobe is high in any cycle.
- R3: The transfer phase (`ph_xfer` high) lasts exactly 2 enabled clocks and always directly follows the initial sample phase.
- R4: The final sample phase (`ph_final` high) lasts 2, 4, 8 or 16 enabled clocks for `sts` = 00, 01, 10 or 11 respectively.
- R5: The resolution phase (`ph_resolve` high) lasts 10 enabled clocks when `res10`=0 and 12 when `res10`=1. An 8-bit conversion with `sts`=00 therefore takes 16 enabled clocks in total.
- R6: During resolution, one bit is decided per enabled clock, from bit 9 downward. `dac_code` shows the bits already decided plus a 1 in the bit under trial, so the first trial code of a conversion is 10'h200. The trial bit is kept when `cmp_hi`=1 (input at or above the trial voltage) and cleared otherwise. The two enabled clocks after the last decision are an end-of-conversion cycle and a store cycle.
- R7: In 8-bit mode only bits 9..2 are decided, and bits 1..0 of the stored result are 0 (left-aligned). In 10-bit mode all ten bits are decided.
- R8: At the store cycle the decided code is written to channel c's result field `result_flat[10*c+9 : 10*c]`, and `ccf[c]` is set.
- R9: Channels are converted in ascending order from 0. After channel 3 (`mode8`=0) or channel 7 (`mode8`=1), `seq_done` rises and the block goes idle with no phase strobe high.
- R10: In a cycle with `adc_ce` low and `start` low, no phase strobe, channel select, trial code or flag changes.
- R11: Completion flags and `seq_done` stay set until the next start or reset, and result fields keep their values while idle.
- R12: Reset leaves the block idle with all result fields zero, all flags clear, `dac_code` zero and channel 0 selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_ce | input | 1 | Converter clock enable; phases advance only when high |
| start | input | 1 | Start or restart a sequence |
| res10 | input | 1 | 1 = 10-bit conversion, 0 = 8-bit conversion |
| sts | input | 2 | Final sample length select (00=2, 01=4, 10=8, 11=16 clocks) |
| mode8 | input | 1 | 1 = eight-channel group, 0 = four-channel group |
| cmp_hi | input | 1 | Comparator decision: input at or above trial voltage |
| ph_init | output | 1 | Initial sample phase active |
| ph_xfer | output | 1 | Transfer phase active |
| ph_final | output | 1 | Final sample phase active |
| ph_resolve | output | 1 | Resolution phase active |
| chan | output | 3 | Selected channel |
| dac_code | output | 10 | Trial code for the DAC array |
| result_flat | output | 80 | Eight 10-bit result fields, channel c at bits 10c+9..10c |
| ccf | output | 8 | Per-channel conversion-complete flags |
| seq_done | output | 1 | Sequence complete |

## Verification
The sequence is run at both resolutions, at all four final-sample lengths and in both group sizes. A comparator model in the bench compares a per-channel input level with the trial code. The input levels include 0, full scale, exact bit boundaries and values whose two low bits are set, which separates a correct bit-by-bit decision from an off-by-one trial order and shows the 8-bit left alignment. The enable is driven both constantly high and in an irregular pattern, so that phase lengths counted in enabled clocks can be told apart from lengths counted in raw clocks. A restart during a running sequence with new input levels shows that the flags clear and that stale results are overwritten.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INIT  = 3'd1,
    PH_XFER  = 3'd2,
    PH_FINAL = 3'd3,
    PH_RES   = 3'd4
  } phase_t;

  localparam int INIT_TICKS = 2;
  localparam int XFER_TICKS = 2;
  localparam int RES_EXTRA  = 2;   // end-of-conversion + store cycles
  localparam int FINAL_MAX  = 16;
endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer
  import sar_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RW  = 10,
  parameter int CHW = $clog2(NCH),
  parameter int CW  = $clog2(((FINAL_MAX > RW + RES_EXTRA) ? FINAL_MAX : RW + RES_EXTRA) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start,
  input  logic           res10_in,
  input  logic [1:0]     sts_in,
  input  logic           mode8_in,
  output phase_t         phase,
  output logic [CW-1:0]  step,
  output logic [CHW-1:0] chan,
  output logic           res10,
  output logic           store,
  output logic           seq_done
);
  phase_t         phase_q, phase_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CHW-1:0] chan_q, chan_d;
  logic           done_q, done_d;
  logic           res10_q, res10_d;
  logic [1:0]     sts_q, sts_d;
  logic           mode8_q, mode8_d;

  logic [CW-1:0]  final_len;
  logic [CW-1:0]  res_len;
  logic [CHW-1:0] last_chan;
  logic           cnt_end;

  always_comb begin
    final_len = CW'(2) << sts_q;
    res_len   = res10_q ? CW'(RW + RES_EXTRA) : CW'(RW - 2 + RES_EXTRA);
    last_chan = mode8_q ? CHW'(NCH - 1) : CHW'(NCH / 2 - 1);
    case (phase_q)
      PH_INIT:  cnt_end = (cnt_q == CW'(INIT_TICKS - 1));
      PH_XFER:  cnt_end = (cnt_q == CW'(XFER_TICKS - 1));
      PH_FINAL: cnt_end = (cnt_q == final_len - CW'(1));
      PH_RES:   cnt_end = (cnt_q == res_len - CW'(1));
      default:  cnt_end = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    chan_d  = chan_q;
    done_d  = done_q;
    res10_d = res10_q;
    sts_d   = sts_q;
    mode8_d = mode8_q;
    store   = 1'b0;
    if (start) begin
      phase_d = PH_INIT;
      cnt_d   = '0;
      chan_d  = '0;
      done_d  = 1'b0;
      res10_d = res10_in;
      sts_d   = sts_in;
      mode8_d = mode8_in;
    end else if (tick && phase_q != PH_IDLE) begin
      if (!cnt_end) begin
        cnt_d = cnt_q + CW'(1);
      end else begin
        cnt_d = '0;
        case (phase_q)
          PH_INIT:  phase_d = PH_XFER;
          PH_XFER:  phase_d = PH_FINAL;
          PH_FINAL: phase_d = PH_RES;
          PH_RES: begin
            store = 1'b1;
            if (chan_q == last_chan) begin
              phase_d = PH_IDLE;
              done_d  = 1'b1;
            end else begin
              phase_d = PH_INIT;
              chan_d  = chan_q + CHW'(1);
            end
          end
          default: phase_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      chan_q  <= '0;
      done_q  <= 1'b0;
      res10_q <= 1'b0;
      sts_q   <= 2'b00;
      mode8_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      chan_q  <= chan_d;
      done_q  <= done_d;
      res10_q <= res10_d;
      sts_q   <= sts_d;
      mode8_q <= mode8_d;
    end
  end

  assign phase    = phase_q;
  assign step     = cnt_q;
  assign chan     = chan_q;
  assign res10    = res10_q;
  assign seq_done = done_q;
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_seq_pkg::*;
#(
  parameter int RW = 10,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  phase_t        phase,
  input  logic [CW-1:0] step,
  input  logic          res10,
  input  logic          cmp_hi,
  output logic [RW-1:0] dac_code,
  output logic [RW-1:0] code
);
  logic [RW-1:0] sar_q, sar_d;
  logic [RW-1:0] trial_bit;
  logic [CW-1:0] nbits;
  logic          deciding;

  always_comb begin
    nbits     = res10 ? CW'(RW) : CW'(RW - 2);
    deciding  = (phase == PH_RES) && (step < nbits);
    trial_bit = {1'b1, {(RW-1){1'b0}}} >> step;
    dac_code  = deciding ? (sar_q | trial_bit) : sar_q;
    sar_d     = sar_q;
    if (start || (tick && phase == PH_INIT)) begin
      sar_d = '0;
    end else if (tick && deciding) begin
      sar_d = cmp_hi ? (sar_q | trial_bit) : (sar_q & ~trial_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sar_q <= '0;
    else        sar_q <= sar_d;
  end

  assign code = sar_q;
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
  parameter int NCH = 8,
  parameter int RW  = 10,
  parameter int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              store,
  input  logic [CHW-1:0]    chan,
  input  logic [RW-1:0]     code,
  output logic [NCH*RW-1:0] result_flat,
  output logic [NCH-1:0]    ccf
);
  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic [RW-1:0] val_q, val_d;
    logic          flag_q, flag_d;
    logic          hit;

    always_comb begin
      hit    = store && (chan == CHW'(c));
      val_d  = hit ? code : val_q;
      flag_d = start ? 1'b0 : (hit ? 1'b1 : flag_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        val_q  <= val_d;
        flag_q <= flag_d;
      end
    end

    assign result_flat[c*RW +: RW] = val_q;
    assign ccf[c]                  = flag_q;
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_ce,
  input  logic              start,
  input  logic              res10,
  input  logic [1:0]        sts,
  input  logic              mode8,
  input  logic              cmp_hi,
  output logic              ph_init,
  output logic              ph_xfer,
  output logic              ph_final,
  output logic              ph_resolve,
  output logic [2:0]        chan,
  output logic [RW-1:0]     dac_code,
  output logic [NCH*RW-1:0] result_flat,
  output logic [NCH-1:0]    ccf,
  output logic              seq_done
);
  localparam int CHW = $clog2(NCH);
  localparam int CW  = $clog2(((FINAL_MAX > RW + RES_EXTRA) ? FINAL_MAX : RW + RES_EXTRA) + 1);

  logic [1:0]     rst_pipe;
  logic           rst_sync_n;
  phase_t         phase;
  logic [CW-1:0]  step;
  logic [CHW-1:0] chan_i;
  logic           res10_q;
  logic           store;
  logic [RW-1:0]  code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sar_phase_timer #(.NCH(NCH), .RW(RW), .CHW(CHW), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (adc_ce),
    .start    (start),
    .res10_in (res10),
    .sts_in   (sts),
    .mode8_in (mode8),
    .phase    (phase),
    .step     (step),
    .chan     (chan_i),
    .res10    (res10_q),
    .store    (store),
    .seq_done (seq_done)
  );

  sar_bit_engine #(.RW(RW), .CW(CW)) u_bits (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (adc_ce),
    .start    (start),
    .phase    (phase),
    .step     (step),
    .res10    (res10_q),
    .cmp_hi   (cmp_hi),
    .dac_code (dac_code),
    .code     (code)
  );

  sar_result_bank #(.NCH(NCH), .RW(RW), .CHW(CHW)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .store       (store),
    .chan        (chan_i),
    .code        (code),
    .result_flat (result_flat),
    .ccf         (ccf)
  );

  assign ph_init    = (phase == PH_INIT);
  assign ph_xfer    = (phase == PH_XFER);
  assign ph_final   = (phase == PH_FINAL);
  assign ph_resolve = (phase == PH_RES);
  assign chan       = 3'(chan_i);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NCH = 8,
  parameter int RW  = 10
) (
  input logic           clk,
  input logic           rst_sync_n,
  input logic           adc_ce,
  input logic           start,
  input logic           ph_init,
  input logic           ph_xfer,
  input logic           ph_final,
  input logic           ph_resolve,
  input logic [2:0]     chan,
  input logic [RW-1:0]  dac_code,
  input logic [NCH-1:0] ccf,
  input logic           seq_done
);
  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> (ph_init && ccf == '0 && chan == 3'd0 && !seq_done));

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ph_init, ph_xfer, ph_final, ph_resolve}));

  // R3
  xfer_before_final_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ph_final) |-> $past(ph_xfer));

  // R9
  idle_when_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seq_done |-> !(ph_init || ph_xfer || ph_final || ph_resolve));

  // R10
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!adc_ce && !start) |=> ($stable({ph_init, ph_xfer, ph_final, ph_resolve})
                             && $stable(chan) && $stable(dac_code) && $stable(ccf)));

  // R11
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start |=> ((ccf & $past(ccf)) == $past(ccf)));
endmodule

bind sar_seq sar_seq_chk #(.NCH(NCH), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .adc_ce     (adc_ce),
  .start      (start),
  .ph_init    (ph_init),
  .ph_xfer    (ph_xfer),
  .ph_final   (ph_final),
  .ph_resolve (ph_resolve),
  .chan       (chan),
  .dac_code   (dac_code),
  .ccf        (ccf),
  .seq_done   (seq_done)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic        clk;
  logic        rst_n;
  logic        adc_ce;
  logic        start;
  logic        res10;
  logic [1:0]  sts;
  logic        mode8;
  logic        cmp_hi;
  logic        ph_init, ph_xfer, ph_final, ph_resolve;
  logic [2:0]  chan;
  logic [9:0]  dac_code;
  logic [79:0] result_flat;
  logic [7:0]  ccf;
  logic        seq_done;

  logic [9:0]  vin [0:7];
  int          n_checks = 0;
  int          n_fail   = 0;
  int          wd       = 0;

  sar_seq uut (
    .clk(clk), .rst_n(rst_n), .adc_ce(adc_ce), .start(start), .res10(res10),
    .sts(sts), .mode8(mode8), .cmp_hi(cmp_hi), .ph_init(ph_init), .ph_xfer(ph_xfer),
    .ph_final(ph_final), .ph_resolve(ph_resolve), .chan(chan), .dac_code(dac_code),
    .result_flat(result_flat), .ccf(ccf), .seq_done(seq_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural comparator: input at or above trial level
  assign cmp_hi = (vin[chan] >= dac_code);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  function automatic logic [9:0] expect_code(input logic [9:0] v, input logic r10);
    return r10 ? v : (v & 10'h3FC);
  endfunction

  // Runs one full sequence; ce_mode 1 drives an irregular enable
  task automatic run_seq(input logic r10, input logic [1:0] s, input logic m8,
                         input bit ce_mode, input string tag);
    int n, flen, rlen, ni, nx, nf, nr, conv, cyc;
    logic [7:0] mask;
    bit prev_init, prev_res, ce;
    n    = m8 ? 8 : 4;
    flen = 2 << s;
    rlen = r10 ? 12 : 10;
    ni = 0; nx = 0; nf = 0; nr = 0; conv = -1; cyc = 0;
    prev_init = 0; prev_res = 0;
    @(negedge clk);
    res10 = r10; sts = s; mode8 = m8;
    start = 1'b1; adc_ce = 1'b0;        // R1: start acts with enable low
    @(negedge clk);
    start = 1'b0;
    res10 = ~r10; sts = ~s; mode8 = ~m8; // R1: later changes must be ignored
    chk(ph_init && ccf == 8'h00 && chan == 3'd0 && !seq_done, {"R1 start ", tag},
        {ph_init, ccf, chan, seq_done}, {1'b1, 8'h00, 3'd0, 1'b0});
    while (!seq_done && cyc < 5000) begin
      if (ph_init && !prev_init) begin
        conv++;
        chk(chan == 3'(conv), {"R9 channel order ", tag}, chan, conv);
      end
      if (ph_resolve && !prev_res && conv == 0)
        chk(dac_code == 10'h200, {"R6 first trial ", tag}, dac_code, 10'h200);
      prev_init = ph_init;
      prev_res  = ph_resolve;
      ce = ce_mode ? ((cyc % 3) != 1) : 1'b1;
      adc_ce = ce;
      if (ce) begin
        ni += int'(ph_init); nx += int'(ph_xfer);
        nf += int'(ph_final); nr += int'(ph_resolve);
      end
      @(negedge clk);
      cyc++;
    end
    adc_ce = 1'b1;
    chk(seq_done, {"R9 done ", tag}, seq_done, 1);
    chk(ni == 2 * n, {"R2 init ticks ", tag}, ni, 2 * n);
    chk(nx == 2 * n, {"R3 transfer ticks ", tag}, nx, 2 * n);
    chk(nf == flen * n, {"R4 final ticks ", tag}, nf, flen * n);
    chk(nr == rlen * n, {"R5 resolve ticks ", tag}, nr, rlen * n);
    if (!r10 && s == 2'b00)
      chk((ni + nx + nf + nr) == 16 * n, {"R5 16-clock total ", tag}, ni + nx + nf + nr, 16 * n);
    if (ce_mode)
      chk(cyc > (ni + nx + nf + nr), {"R10 gated ", tag}, cyc, ni + nx + nf + nr);
    mask = m8 ? 8'hFF : 8'h0F;
    chk(ccf == mask, {"R8 flags ", tag}, ccf, mask);
    chk(!(ph_init | ph_xfer | ph_final | ph_resolve), {"R9 idle ", tag},
        {ph_init, ph_xfer, ph_final, ph_resolve}, 0);
    for (int c = 0; c < n; c++) begin
      chk(result_flat[c*10 +: 10] == expect_code(vin[c], r10),
          r10 ? {"R6 result ", tag} : {"R7 aligned result ", tag},
          result_flat[c*10 +: 10], expect_code(vin[c], r10));
    end
  endtask

  task automatic t_reset();
    chk(result_flat == '0 && ccf == 8'h00 && !seq_done && dac_code == 10'd0 && chan == 3'd0,
        "R12 reset", {ccf, dac_code, chan}, 0);
    chk(!(ph_init | ph_xfer | ph_final | ph_resolve), "R12 idle phases",
        {ph_init, ph_xfer, ph_final, ph_resolve}, 0);
  endtask

  task automatic t_sticky();
    logic [79:0] snap;
    logic [7:0]  f;
    snap = result_flat;
    f    = ccf;
    repeat (20) @(negedge clk);
    chk(ccf == f && seq_done, "R11 sticky flags", ccf, f);
    chk(result_flat == snap, "R11 results held", result_flat[31:0], snap[31:0]);
  endtask

  task automatic t_restart();
    @(negedge clk);
    res10 = 1'b0; sts = 2'b00; mode8 = 1'b1; start = 1'b1; adc_ce = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(ccf[0] == 1'b1 && !seq_done, "R11 mid-sequence flag", ccf, 1);
    for (int c = 0; c < 8; c++) vin[c] = 10'(c * 97 + 5);
    run_seq(1'b1, 2'b01, 1'b1, 1'b0, "restart");
  endtask

  initial begin
    rst_n = 1'b0; adc_ce = 1'b0; start = 1'b0; res10 = 1'b0; sts = 2'b00; mode8 = 1'b0;
    vin[0] = 10'd0;   vin[1] = 10'h3FF; vin[2] = 10'h200; vin[3] = 10'd3;
    vin[4] = 10'h1FF; vin[5] = 10'd513; vin[6] = 10'h2AB; vin[7] = 10'h155;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_seq(1'b0, 2'b00, 1'b0, 1'b0, "8b s0 m4");
    t_sticky();
    run_seq(1'b1, 2'b11, 1'b1, 1'b0, "10b s3 m8");
    run_seq(1'b0, 2'b10, 1'b1, 1'b1, "8b s2 m8 gated");
    run_seq(1'b1, 2'b01, 1'b0, 1'b1, "10b s1 m4 gated");
    t_restart();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    finish_run();
  end
endmodule